// File: doc/BRIEF.md
# Exception Entry State-Save Unit

This block performs the register side of a processor taking an exception. On a one-cycle request it receives an exception code, a subtype, an error code, the current program counter and the current machine state word. It then writes a saved program counter and a saved status word into one of two save pairs, either the ordinary pair or the hypervisor pair. It also produces the machine state word and the handler address that the core loads next. Configuration inputs decide the rest: whether the core supports a hypervisor, which relocated-vector mode is active, whether handlers run little-endian, and which prefix is ORed into every vector.

The unit also handles wake-up from a power-saving state. In that state every exception except a machine check is steered to the reset handler, and the wake cause is encoded in the saved status word. Each request ends in exactly one of three outcomes: a completed entry, an ignored floating-point trap, or an illegal-delivery report. Only a completed entry changes the architectural outputs and wipes the load reservation.

Top module: `exc_entry_unit`

## Requirements
- R1: While `rstN` is low, every saved register, `newMsr`, `vector`, the pulse outputs and `checkstop` are zero, and `resvAddr` is all ones.
- R2: When `excValid` is high, all results appear at the next rising clock edge. For a completed entry, `entryDone` pulses for one cycle. The ordinary pair then holds the PC and the status word, which is the current MSR with the mask 0x783F0000 cleared. Codes DSI=2, EXTERNAL=3, DECR=5 and DOORBELL=7 need nothing further.
- R3: The new MSR is zero except for the following bits. ME (bit 12) and HV (bit 60) are copied from the old MSR, unless a later rule changes them. LE (bit 0) is set when `ileFlag` is 1.
- R4: A machine check (code 1) clears ME in the new MSR and sets HV when `hvCapable` is 1. If the old ME was 0, `checkstop` is set and stays set until reset, and the entry still completes.
- R5: A program exception (code 4) ORs one bit into the saved status word, chosen by `subType`: 0 (floating point) gives 0x00100000, 1 (illegal) gives 0x00080000, 2 (privileged) gives 0x00040000, and 3 (trap) gives 0x00020000.
- R6: A floating-point program exception is dropped when FP (bit 13) is 0 or when both FE0 (bit 11) and FE1 (bit 8) are 0. In that case `fpIgnored` pulses and no other output changes.
- R7: A system call (code 8) saves PC+4. When `errCode` equals 1, it also sets HV in the new MSR.
- R8: When `inPowerSave` is 1, any code except machine check is handled as reset (code 0). The saved status word gets 0x10000, plus a 4-bit cause shifted left by 18: reset 0x4, external 0x8, decrementer 0x6, doorbell 0x5, hypervisor doorbell (code 10) 0x3, maintenance (code 9) 0xA. A machine check in this state also gets 0x10000. Any other code is reported as an illegal delivery.
- R9: A reset (code 0) with POW (bit 18) set in the old MSR ORs 0x10000 into the saved status word and sets ME. A reset sets HV when `hvCapable` is 1.
- R10: The hypervisor classes HDECR=6, MAINT=9 and HDOORBELL=10 write the hypervisor pair instead of the ordinary pair. They set HV and copy RI (bit 1) from the old MSR.
- R11: `vector` is the base for the code ORed with `vecPrefix`. The bases are: 0 to 0x100, 1 to 0x200, 2 to 0x300, 3 to 0x500, 4 to 0x700, 5 to 0x900, 6 to 0x980, 7 to 0xA00, 8 to 0xC00, 9 to 0xE60 and 10 to 0xE80.
- R12: In `ailMode` 2 the vector is ORed with 0x18000, and in mode 3 with 0xC000000000004000. Either mode also sets IR (bit 5) and DR (bit 4) in the new MSR. The relocation is skipped in four cases: modes 0 and 1, an old MSR with IR or DR clear, a move from non-HV to HV, and machine check or reset.
- R13: A completed entry sets `resvAddr` to all ones. `resvSet` loads `resvSetAddr` into it, but a completed entry in the same cycle takes priority.
- R14: Some requests pulse `illegalDeliv` and change nothing else. These are codes 11 to 15, and any request that would set HV or use the hypervisor pair while `hvCapable` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| excValid | input | 1 | Exception request, one cycle |
| excCode | input | 4 | Exception code |
| subType | input | 2 | Program exception subtype |
| errCode | input | 8 | Error code (system call level) |
| curPc | input | 64 | Program counter at the exception |
| curMsr | input | 64 | Machine state word before entry |
| hvCapable | input | 1 | Core supports hypervisor state |
| ailMode | input | 2 | Relocated-vector mode |
| ileFlag | input | 1 | Handlers run little-endian |
| vecPrefix | input | 64 | Prefix ORed into the vector |
| inPowerSave | input | 1 | Core is waking from power-save |
| resvSet | input | 1 | Load a reservation address |
| resvSetAddr | input | 64 | Reservation address to load |
| entryDone | output | 1 | Entry completed (pulse) |
| illegalDeliv | output | 1 | Illegal delivery reported (pulse) |
| fpIgnored | output | 1 | Floating-point trap dropped (pulse) |
| checkstop | output | 1 | Sticky checkstop state |
| savePc | output | 64 | Ordinary pair: saved PC |
| saveStatus | output | 64 | Ordinary pair: saved status word |
| hSavePc | output | 64 | Hypervisor pair: saved PC |
| hSaveStatus | output | 64 | Hypervisor pair: saved status word |
| newMsr | output | 64 | Machine state word for the handler |
| vector | output | 64 | Handler address |
| resvAddr | output | 64 | Load reservation address |

## Verification
Every result is registered once. The outcome pulses, both save pairs, `newMsr`, `vector`, `resvAddr` and `checkstop` are therefore all due on the first rising edge after the cycle in which `excValid` is high. The bench changes inputs on falling edges, holds `excValid` for exactly one cycle and compares every output on the next falling edge. Each reservation load is issued one full cycle before the exception it precedes, so the entry's overriding clear is seen in isolation. A bench-side copy of each held register expects unchanged values after dropped or illegal requests.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int XLEN   = 64;
  localparam int CODE_W = 4;
  localparam int ERR_W  = 8;
  localparam int VBASE_W = 12;

  typedef enum logic [CODE_W-1:0] {
    EX_RESET     = 4'd0,
    EX_MCHECK    = 4'd1,
    EX_DSI       = 4'd2,
    EX_EXTERNAL  = 4'd3,
    EX_PROGRAM   = 4'd4,
    EX_DECR      = 4'd5,
    EX_HDECR     = 4'd6,
    EX_DOORBELL  = 4'd7,
    EX_SYSCALL   = 4'd8,
    EX_MAINT     = 4'd9,
    EX_HDOORBELL = 4'd10
  } excCode_e;

  localparam int MSR_LE  = 0;
  localparam int MSR_RI  = 1;
  localparam int MSR_DR  = 4;
  localparam int MSR_IR  = 5;
  localparam int MSR_FE1 = 8;
  localparam int MSR_FE0 = 11;
  localparam int MSR_ME  = 12;
  localparam int MSR_FP  = 13;
  localparam int MSR_POW = 18;
  localparam int MSR_HV  = 60;

  localparam int RESUME_BIT  = 16;
  localparam int CAUSE_SHIFT = 18;
  localparam int PROG_SHIFT  = 17;

  localparam logic [XLEN-1:0] SAVE_CLR_MASK = 64'h0000_0000_783F_0000;
  localparam logic [XLEN-1:0] AIL_LOW_OFS   = 64'h0000_0000_0001_8000;
  localparam logic [XLEN-1:0] AIL_HIGH_OFS  = 64'hC000_0000_0000_4000;

  // Strobes from control to datapath
  typedef struct packed {
    logic        commit;
    logic        toHvPair;
    logic        setHv;
    logic        copyRi;
    logic        setMe;
    logic        clrMe;
    logic        ailOk;
    logic        pcPlus4;
    logic        illegal;
    logic        fpIgnore;
    logic        checkstop;
    logic        wake;
    logic [3:0]  progBits;
    logic [3:0]  cause;
    logic [CODE_W-1:0] vecCode;
  } entryCtl_t;

  function automatic logic [VBASE_W-1:0] vecBase(input logic [CODE_W-1:0] code);
    case (code)
      EX_RESET:     vecBase = 12'h100;
      EX_MCHECK:    vecBase = 12'h200;
      EX_DSI:       vecBase = 12'h300;
      EX_EXTERNAL:  vecBase = 12'h500;
      EX_PROGRAM:   vecBase = 12'h700;
      EX_DECR:      vecBase = 12'h900;
      EX_HDECR:     vecBase = 12'h980;
      EX_DOORBELL:  vecBase = 12'hA00;
      EX_SYSCALL:   vecBase = 12'hC00;
      EX_MAINT:     vecBase = 12'hE60;
      EX_HDOORBELL: vecBase = 12'hE80;
      default:      vecBase = 12'h000;
    endcase
  endfunction
endpackage

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
(
  input  logic [CODE_W-1:0] excCode,
  input  logic [1:0]        subType,
  input  logic [ERR_W-1:0]  errCode,
  input  logic              hvCapable,
  input  logic              inPowerSave,
  input  logic              msrMe,
  input  logic              msrPow,
  input  logic              msrFp,
  input  logic              msrFe0,
  input  logic              msrFe1,
  output entryCtl_t         ctl
);
  logic [CODE_W-1:0] effCode;
  logic [3:0]        wakeCause;
  logic              wakeBad;
  logic              unknownCode;
  logic              fpDrop;
  logic              hvFault;
  logic              anyBad;
  entryCtl_t         raw;

  // Power-save redirection: everything but machine check goes to reset
  always_comb begin
    wakeCause = 4'h0;
    wakeBad   = 1'b0;
    effCode   = excCode;
    if (inPowerSave && excCode != EX_MCHECK) begin
      effCode = EX_RESET;
      case (excCode)
        EX_RESET:     wakeCause = 4'h4;
        EX_EXTERNAL:  wakeCause = 4'h8;
        EX_DECR:      wakeCause = 4'h6;
        EX_DOORBELL:  wakeCause = 4'h5;
        EX_HDOORBELL: wakeCause = 4'h3;
        EX_MAINT:     wakeCause = 4'hA;
        default:      wakeBad   = 1'b1;
      endcase
    end
  end

  // Per-class decode
  always_comb begin
    raw         = '0;
    unknownCode = 1'b0;
    fpDrop      = 1'b0;
    raw.vecCode = effCode;
    raw.wake    = inPowerSave;
    raw.cause   = wakeCause;
    case (effCode)
      EX_RESET: begin
        raw.setMe = msrPow;
        raw.setHv = hvCapable;
      end
      EX_MCHECK: begin
        raw.clrMe     = 1'b1;
        raw.setHv     = hvCapable;
        raw.checkstop = ~msrMe;
      end
      EX_DSI, EX_EXTERNAL, EX_DECR, EX_DOORBELL: raw.ailOk = 1'b1;
      EX_PROGRAM: begin
        raw.ailOk    = 1'b1;
        raw.progBits = 4'b1000 >> subType;
        fpDrop       = (subType == 2'd0) && (~msrFp || (~msrFe0 && ~msrFe1));
      end
      EX_SYSCALL: begin
        raw.ailOk   = 1'b1;
        raw.pcPlus4 = 1'b1;
        raw.setHv   = (errCode == ERR_W'(1));
      end
      EX_HDECR, EX_MAINT, EX_HDOORBELL: begin
        raw.ailOk    = 1'b1;
        raw.toHvPair = 1'b1;
        raw.setHv    = 1'b1;
        raw.copyRi   = 1'b1;
      end
      default: unknownCode = 1'b1;
    endcase
  end

  assign hvFault = ~hvCapable & (raw.setHv | raw.toHvPair);
  assign anyBad  = wakeBad | unknownCode | hvFault;

  always_comb begin
    ctl           = raw;
    ctl.illegal   = anyBad;
    ctl.fpIgnore  = fpDrop & ~anyBad;
    ctl.commit    = ~anyBad & ~fpDrop;
    ctl.checkstop = raw.checkstop & ~anyBad & ~fpDrop;
  end
endmodule

// File: rtl/exc_entry_dp.sv
module exc_entry_dp
  import exc_entry_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            excValid,
  input  entryCtl_t       ctl,
  input  logic [XLEN-1:0] curPc,
  input  logic [XLEN-1:0] curMsr,
  input  logic [1:0]      ailMode,
  input  logic            ileFlag,
  input  logic [XLEN-1:0] vecPrefix,
  input  logic            resvSet,
  input  logic [XLEN-1:0] resvSetAddr,
  output logic            entryDone,
  output logic            illegalDeliv,
  output logic            fpIgnored,
  output logic            checkstop,
  output logic [XLEN-1:0] savePc,
  output logic [XLEN-1:0] saveStatus,
  output logic [XLEN-1:0] hSavePc,
  output logic [XLEN-1:0] hSaveStatus,
  output logic [XLEN-1:0] newMsr,
  output logic [XLEN-1:0] vector,
  output logic [XLEN-1:0] resvAddr
);
  logic [XLEN-1:0] statusWord;
  logic [XLEN-1:0] msrNext;
  logic [XLEN-1:0] vecNext;
  logic [XLEN-1:0] pcNext;
  logic            hvNext;
  logic            ailTake;
  logic            doCommit;

  assign doCommit = excValid & ctl.commit;

  // Saved status word
  always_comb begin
    statusWord = curMsr & ~SAVE_CLR_MASK;
    statusWord = statusWord | (XLEN'(ctl.progBits) << PROG_SHIFT);
    if (ctl.wake) begin
      statusWord[RESUME_BIT] = 1'b1;
      statusWord = statusWord | (XLEN'(ctl.cause) << CAUSE_SHIFT);
    end
    if (ctl.setMe) statusWord[RESUME_BIT] = 1'b1;
  end

  assign pcNext  = ctl.pcPlus4 ? curPc + XLEN'(4) : curPc;
  assign hvNext  = curMsr[MSR_HV] | ctl.setHv;
  assign ailTake = ctl.ailOk && ailMode[1] && curMsr[MSR_IR] && curMsr[MSR_DR]
                   && !(hvNext && !curMsr[MSR_HV]);

  // Handler MSR
  always_comb begin
    msrNext          = '0;
    msrNext[MSR_HV]  = hvNext;
    msrNext[MSR_ME]  = (curMsr[MSR_ME] | ctl.setMe) & ~ctl.clrMe;
    msrNext[MSR_RI]  = ctl.copyRi & curMsr[MSR_RI];
    msrNext[MSR_IR]  = ailTake;
    msrNext[MSR_DR]  = ailTake;
    msrNext[MSR_LE]  = ileFlag;
  end

  // Handler address
  always_comb begin
    vecNext = XLEN'(vecBase(ctl.vecCode)) | vecPrefix;
    if (ailTake) vecNext = vecNext | (ailMode[0] ? AIL_HIGH_OFS : AIL_LOW_OFS);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      entryDone    <= 1'b0;
      illegalDeliv <= 1'b0;
      fpIgnored    <= 1'b0;
      checkstop    <= 1'b0;
      savePc       <= '0;
      saveStatus   <= '0;
      hSavePc      <= '0;
      hSaveStatus  <= '0;
      newMsr       <= '0;
      vector       <= '0;
      resvAddr     <= '1;
    end else begin
      entryDone    <= doCommit;
      illegalDeliv <= excValid & ctl.illegal;
      fpIgnored    <= excValid & ctl.fpIgnore;
      if (doCommit) begin
        if (ctl.toHvPair) begin
          hSavePc     <= pcNext;
          hSaveStatus <= statusWord;
        end else begin
          savePc     <= pcNext;
          saveStatus <= statusWord;
        end
        newMsr   <= msrNext;
        vector   <= vecNext;
        resvAddr <= '1;
        if (ctl.checkstop) checkstop <= 1'b1;
      end else if (resvSet) begin
        resvAddr <= resvSetAddr;
      end
    end
  end
endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
  import exc_entry_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               excValid,
  input  logic [CODE_W-1:0]  excCode,
  input  logic [1:0]         subType,
  input  logic [ERR_W-1:0]   errCode,
  input  logic [XLEN-1:0]    curPc,
  input  logic [XLEN-1:0]    curMsr,
  input  logic               hvCapable,
  input  logic [1:0]         ailMode,
  input  logic               ileFlag,
  input  logic [XLEN-1:0]    vecPrefix,
  input  logic               inPowerSave,
  input  logic               resvSet,
  input  logic [XLEN-1:0]    resvSetAddr,
  output logic               entryDone,
  output logic               illegalDeliv,
  output logic               fpIgnored,
  output logic               checkstop,
  output logic [XLEN-1:0]    savePc,
  output logic [XLEN-1:0]    saveStatus,
  output logic [XLEN-1:0]    hSavePc,
  output logic [XLEN-1:0]    hSaveStatus,
  output logic [XLEN-1:0]    newMsr,
  output logic [XLEN-1:0]    vector,
  output logic [XLEN-1:0]    resvAddr
);
  entryCtl_t ctl;

  exc_entry_ctrl u_ctrl (
    .excCode     (excCode),
    .subType     (subType),
    .errCode     (errCode),
    .hvCapable   (hvCapable),
    .inPowerSave (inPowerSave),
    .msrMe       (curMsr[MSR_ME]),
    .msrPow      (curMsr[MSR_POW]),
    .msrFp       (curMsr[MSR_FP]),
    .msrFe0      (curMsr[MSR_FE0]),
    .msrFe1      (curMsr[MSR_FE1]),
    .ctl         (ctl)
  );

  exc_entry_dp u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .excValid     (excValid),
    .ctl          (ctl),
    .curPc        (curPc),
    .curMsr       (curMsr),
    .ailMode      (ailMode),
    .ileFlag      (ileFlag),
    .vecPrefix    (vecPrefix),
    .resvSet      (resvSet),
    .resvSetAddr  (resvSetAddr),
    .entryDone    (entryDone),
    .illegalDeliv (illegalDeliv),
    .fpIgnored    (fpIgnored),
    .checkstop    (checkstop),
    .savePc       (savePc),
    .saveStatus   (saveStatus),
    .hSavePc      (hSavePc),
    .hSaveStatus  (hSaveStatus),
    .newMsr       (newMsr),
    .vector       (vector),
    .resvAddr     (resvAddr)
  );
endmodule

// File: rtl/exc_entry_checker.sv
module exc_entry_checker (
  input logic        clk,
  input logic        rstN,
  input logic        excValid,
  input logic [3:0]  excCode,
  input logic [63:0] curPc,
  input logic [63:0] curMsr,
  input logic        hvCapable,
  input logic        inPowerSave,
  input logic        entryDone,
  input logic        illegalDeliv,
  input logic        fpIgnored,
  input logic        checkstop,
  input logic [63:0] savePc,
  input logic [63:0] hSavePc,
  input logic [63:0] newMsr,
  input logic [63:0] resvAddr
);
  assert_resv_clear_R13: assert property (@(posedge clk) disable iff (!rstN)
    entryDone |-> (resvAddr == 64'hFFFF_FFFF_FFFF_FFFF));

  assert_single_outcome_R14: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({entryDone, illegalDeliv, fpIgnored}));

  assert_hold_on_reject_R6: assert property (@(posedge clk) disable iff (!rstN)
    (illegalDeliv || fpIgnored) |-> ($stable(savePc) && $stable(hSavePc) && $stable(newMsr)));

  assert_mcheck_clears_me_R4: assert property (@(posedge clk) disable iff (!rstN)
    (excValid && excCode == 4'd1) |=> (!entryDone || !newMsr[12]));

  assert_checkstop_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
    checkstop |=> checkstop);

  assert_syscall_next_pc_R7: assert property (@(posedge clk) disable iff (!rstN)
    (excValid && excCode == 4'd8 && !inPowerSave) |=> (!entryDone || savePc == $past(curPc) + 64'd4));

  assert_hv_needs_capable_R14: assert property (@(posedge clk) disable iff (!rstN)
    (excValid && !hvCapable && !curMsr[60]) |=> !(entryDone && newMsr[60]));
endmodule

bind exc_entry_unit exc_entry_checker u_checker (
  .clk          (clk),
  .rstN         (rstN),
  .excValid     (excValid),
  .excCode      (excCode),
  .curPc        (curPc),
  .curMsr       (curMsr),
  .hvCapable    (hvCapable),
  .inPowerSave  (inPowerSave),
  .entryDone    (entryDone),
  .illegalDeliv (illegalDeliv),
  .fpIgnored    (fpIgnored),
  .checkstop    (checkstop),
  .savePc       (savePc),
  .hSavePc      (hSavePc),
  .newMsr       (newMsr),
  .resvAddr     (resvAddr)
);

// File: tb/exc_entry_unit_tb.sv
`timescale 1ns/1ps
module exc_entry_unit_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        excValid = 1'b0;
  logic [3:0]  excCode = '0;
  logic [1:0]  subType = '0;
  logic [7:0]  errCode = '0;
  logic [63:0] curPc = '0;
  logic [63:0] curMsr = '0;
  logic        hvCapable = 1'b0;
  logic [1:0]  ailMode = '0;
  logic        ileFlag = 1'b0;
  logic [63:0] vecPrefix = '0;
  logic        inPowerSave = 1'b0;
  logic        resvSet = 1'b0;
  logic [63:0] resvSetAddr = '0;
  logic        entryDone, illegalDeliv, fpIgnored, checkstop;
  logic [63:0] savePc, saveStatus, hSavePc, hSaveStatus, newMsr, vector, resvAddr;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  logic [63:0] ePc = '0, eSt = '0, eHPc = '0, eHSt = '0, eMsr = '0, eVec = '0;
  logic        eCs = 1'b0;

  always #4 clk = ~clk;

  exc_entry_unit u_dut (
    .clk(clk), .rstN(rstN), .excValid(excValid), .excCode(excCode), .subType(subType),
    .errCode(errCode), .curPc(curPc), .curMsr(curMsr), .hvCapable(hvCapable),
    .ailMode(ailMode), .ileFlag(ileFlag), .vecPrefix(vecPrefix), .inPowerSave(inPowerSave),
    .resvSet(resvSet), .resvSetAddr(resvSetAddr), .entryDone(entryDone),
    .illegalDeliv(illegalDeliv), .fpIgnored(fpIgnored), .checkstop(checkstop),
    .savePc(savePc), .saveStatus(saveStatus), .hSavePc(hSavePc), .hSaveStatus(hSaveStatus),
    .newMsr(newMsr), .vector(vector), .resvAddr(resvAddr)
  );

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [63:0] baseOf(input int c);
    case (c)
      0: return 64'h100;  1: return 64'h200;  2: return 64'h300;  3: return 64'h500;
      4: return 64'h700;  5: return 64'h900;  6: return 64'h980;  7: return 64'hA00;
      8: return 64'hC00;  9: return 64'hE60;  10: return 64'hE80;
      default: return 64'h0;
    endcase
  endfunction

  task automatic runCase(input int code, input int sub, input int lvl, input logic [63:0] msr,
                         input int ail, input bit hvc, input bit ps, input bit ile, input int idx);
    int eff; int cause; bit bad; bit hvClass; bit sysHv; bit newHv; bit fpIgn; bit commit; bit ailOn;
    logic [63:0] st, nm, vec, pc, pre, raddr;
    string tag;
    pre   = {32'h0, idx[11:0], 20'h0} & 64'h0000_0000_FFF0_0000;
    pc    = 64'h0000_1234_0000_0000 + (idx << 2);
    raddr = 64'h0000_0000_00AB_0000 + idx;
    eff = code; cause = 0; bad = 0;
    if (ps && code != 1) begin
      case (code)
        0: cause = 4; 3: cause = 8; 5: cause = 6; 7: cause = 5; 10: cause = 3; 9: cause = 'hA;
        default: bad = 1;
      endcase
      eff = 0;
    end
    if (eff > 10) bad = 1;
    hvClass = (eff == 6 || eff == 9 || eff == 10);
    sysHv   = (eff == 8 && lvl == 1);
    if (!hvc && (hvClass || sysHv)) bad = 1;
    newHv = msr[60] || ((eff == 0 || eff == 1) && hvc) || hvClass || sysHv;
    fpIgn = !bad && eff == 4 && sub == 0 && (!msr[13] || (!msr[11] && !msr[8]));
    commit = !bad && !fpIgn;
    st = msr & ~64'h783F0000;
    if (ps) st = st | 64'h10000 | (64'(cause) << 18);
    if (eff == 0 && msr[18]) st = st | 64'h10000;
    if (eff == 4) st = st | (64'h1 << (20 - sub));
    ailOn = ail >= 2 && eff != 0 && eff != 1 && msr[5] && msr[4] && !(newHv && !msr[60]);
    nm = '0;
    nm[60] = newHv;
    nm[12] = (msr[12] || (eff == 0 && msr[18])) && eff != 1;
    nm[1]  = hvClass && msr[1];
    nm[5]  = ailOn; nm[4] = ailOn;
    nm[0]  = ile;
    vec = baseOf(eff) | pre;
    if (ailOn) vec = vec | ((ail == 3) ? 64'hC000_0000_0000_4000 : 64'h18000);
    if (ps) tag = "R8";
    else if (eff == 0) tag = "R9";
    else if (eff == 1) tag = "R4";
    else if (eff == 4) tag = "R5";
    else if (eff == 8) tag = "R7";
    else if (hvClass) tag = "R10";
    else tag = "R2";

    @(negedge clk);
    resvSet = 1'b1; resvSetAddr = raddr; excValid = 1'b0;
    @(negedge clk);
    resvSet = 1'b0;
    excValid = 1'b1; excCode = 4'(code); subType = 2'(sub); errCode = 8'(lvl);
    curPc = pc; curMsr = msr; hvCapable = hvc; ailMode = 2'(ail); ileFlag = ile;
    vecPrefix = pre; inPowerSave = ps;
    @(negedge clk);
    excValid = 1'b0;
    if (commit) begin
      if (hvClass) begin eHPc = (eff == 8) ? pc + 4 : pc; eHSt = st; end
      else begin ePc = (eff == 8) ? pc + 4 : pc; eSt = st; end
      eMsr = nm; eVec = vec;
      if (eff == 1 && !msr[12]) eCs = 1'b1;
    end
    chk(fpIgn ? "R6" : "R2", "entryDone", 64'(entryDone), 64'(commit));
    chk("R14", "illegalDeliv", 64'(illegalDeliv), 64'(bad));
    chk("R6", "fpIgnored", 64'(fpIgnored), 64'(fpIgn));
    chk(tag, "savePc", savePc, ePc);
    chk(tag, "saveStatus", saveStatus, eSt);
    chk("R10", "hSavePc", hSavePc, eHPc);
    chk("R10", "hSaveStatus", hSaveStatus, eHSt);
    chk("R3", "newMsr", newMsr, eMsr);
    chk(ail >= 2 ? "R12" : "R11", "vector", vector, eVec);
    chk("R13", "resvAddr", resvAddr, commit ? 64'hFFFF_FFFF_FFFF_FFFF : raddr);
    chk("R4", "checkstop", 64'(checkstop), 64'(eCs));
  endtask

  initial begin
    logic [63:0] pats [4];
    int idx;
    pats[0] = 64'hFFFF_FFFF_FFFF_FFFF;
    pats[1] = 64'h0;
    pats[2] = 64'h0000_0000_0000_3832;
    pats[3] = 64'h0000_0000_0004_0130;
    idx = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "entryDone", 64'(entryDone), 64'h0);
    chk("R1", "checkstop", 64'(checkstop), 64'h0);
    chk("R1", "savePc", savePc, 64'h0);
    chk("R1", "hSaveStatus", hSaveStatus, 64'h0);
    chk("R1", "newMsr", newMsr, 64'h0);
    chk("R1", "vector", vector, 64'h0);
    chk("R1", "resvAddr", resvAddr, 64'hFFFF_FFFF_FFFF_FFFF);
    rstN = 1'b1;
    for (int ps = 0; ps < 2; ps++)
      for (int hvc = 0; hvc < 2; hvc++)
        for (int code = 0; code < 16; code++)
          for (int sub = 0; sub < ((code == 4) ? 4 : (code == 8 ? 2 : 1)); sub++)
            for (int p = 0; p < 4; p++)
              for (int ail = 0; ail < 4; ail++) begin
                idx++;
                runCase(code, (code == 4) ? sub : 0, (code == 8) ? sub : 0, pats[p],
                        ail, hvc[0], ps[0], idx[0], idx);
              end
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule